// File: doc/BRIEF.md
# Page Table Entry Run Writer

This block turns one mapping request into a stream of 32-bit word writes that fill a contiguous range of 64-bit page table entries. A request names the first entry index, how many entries to fill, a physical base address, a memory type, a page-size shift, a compression tag base, a byte delta and two access flags. The block splits the range into aligned power-of-two runs of up to 128 entries. It encodes every entry and presents each word as an address/data pair on a valid/ready write port. The backing memory sits outside the block and is not part of it.

All entries in one run carry the same physical address and tag. The base-two logarithm of the run length is stamped into every one of them. Between runs, the physical address and the byte delta both advance by the run's length times the page size. An unmap request walks the same range and writes zero to every word. A single global stolen-memory offset, when nonzero, relocates every mapping and selects target 3.

Top module: `pte_run_writer`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `wr_valid` is 0 and `done` is 0.
- R2: Entry i is written as two words: the low word at byte address i*8, then the high word at i*8+4. Entries go in ascending order, and one word moves per cycle in which `wr_valid` and `wr_ready` are both 1. While `wr_ready` is 0, address and data hold.
- R3: Mapped low word: bit 0 = 1, bit 3 = NOT write-only, bits 5:4 = target, bit 6 = system-coherent flag, and the remaining bits OR in physical address bits 31:0.
- R4: Mapped high word: bits 7:0 = physical address bits 39:32, and bits 16:8 = the 9-bit memory type (entry bits 48:40).
- R5: If `stolen_base` is nonzero, it is added to the physical address and the target is 3. Otherwise the target is 0.
- R6: At each run start, the run length is 2^s. The size s is the largest value from 7 down to 0 for which the remaining count is at least 2^s and the current index is a multiple of 2^s. The value s is written in low-word bits 9:7 of every entry in the run.
- R7: Every entry in a run uses the same physical address. The next run's address is the previous one plus 2^s shifted left by the page-size shift.
- R8: The compression factor c is memory type bits 8:7. When c is nonzero, high-word bits 31:17 hold (tag_base + (delta>>16)*c) mod 2^15, evaluated per run, and delta advances per run like the address. When c is 0, those bits are 0.
- R9: For an unmap request, every word of the range is written as zero, with the same address order as R2.
- R10: `done` is 1 for exactly one cycle, directly after the last word is accepted. `req_ready` is 0 while words are pending, and a request presented then is ignored.
- R11: A request with count 0 produces no write, and `done` is 1 in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stolen_base | input | 40 | Global relocation offset, 0 = none |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_unmap | input | 1 | Write zero entries |
| req_index | input | 20 | First entry index |
| req_count | input | 20 | Number of entries |
| req_phys | input | 40 | Physical base address |
| req_mtype | input | 9 | Memory type |
| req_pshift | input | 6 | log2 of page size in bytes |
| req_tag_base | input | 15 | Compression tag base |
| req_delta | input | 40 | Byte delta feeding the tag |
| req_sys | input | 1 | System-coherent mapping |
| req_wo | input | 1 | Write-only mapping |
| wr_valid | output | 1 | Word write present |
| wr_ready | input | 1 | Word write accepted |
| wr_addr | output | 23 | Byte address of the word |
| wr_data | output | 32 | Word value |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some runs end on a cycle where the sink stalls. In those cases the run turnover (new size, advanced address, recomputed tag) and the held output must both be correct. The bench drops `wr_ready` in a fixed rhythm that sometimes lands on the last high word of a run. It checks that the first entry of the next run carries the new size field, the moved address and the new tag. A second collision happens when a new request arrives while a run is still writing. The bench injects a different request at that point and judges from the word stream and `req_ready` that the request was dropped.

// File: rtl/pte_pkg.sv
package pte_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

    // Bit positions inside the 64-bit entry
    localparam int unsigned POS_VALID = 0;
    localparam int unsigned POS_RDOK  = 3;
    localparam int unsigned POS_TGT   = 4;
    localparam int unsigned POS_SYS   = 6;
    localparam int unsigned POS_LOG   = 7;
    localparam int unsigned POS_MTYPE = 40;
    localparam int unsigned POS_TAG   = 49;
    localparam int unsigned COMP_LSB  = 7;
    localparam int unsigned DELTA_SH  = 16;

endpackage

// File: rtl/pte_chunk_pick.sv
module pte_chunk_pick #(
    parameter int IDX_W   = 20,
    parameter int CNT_W   = 20,
    parameter int MAX_LOG = 7,
    parameter int LOG_W   = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] remain,
    output logic [LOG_W-1:0] log_sz
);
    logic [MAX_LOG:0] fits;

    for (genvar s = 0; s <= MAX_LOG; s++) begin : g_fit
        localparam int unsigned SZ = 1 << s;
        assign fits[s] = (remain >= CNT_W'(SZ)) && ((idx & IDX_W'(SZ - 1)) == '0);
    end

    // Ascending scan: the largest fitting size wins
    always_comb begin
        log_sz = '0;
        for (int s = 0; s <= MAX_LOG; s++) begin
            if (fits[s]) log_sz = LOG_W'(s);
        end
    end
endmodule

// File: rtl/pte_tag_calc.sv
module pte_tag_calc #(
    parameter int PHYS_W = 40,
    parameter int TAG_W  = 15
) (
    input  logic [TAG_W-1:0]  tag_base,
    input  logic [PHYS_W-1:0] delta,
    input  logic [1:0]        comp,
    output logic [TAG_W-1:0]  tag
);
    import pte_pkg::*;

    logic [TAG_W-1:0] units;

    always_comb begin
        units = TAG_W'(delta >> DELTA_SH);
        tag   = tag_base + TAG_W'(units * TAG_W'(comp));
    end
endmodule

// File: rtl/pte_entry_enc.sv
module pte_entry_enc #(
    parameter int PHYS_W  = 40,
    parameter int MTYPE_W = 9,
    parameter int TAG_W   = 15,
    parameter int LOG_W   = 3
) (
    input  logic [PHYS_W-1:0]  phys,
    input  logic [1:0]         tgt,
    input  logic               sys,
    input  logic               wo,
    input  logic [LOG_W-1:0]   log_sz,
    input  logic [MTYPE_W-1:0] mtype,
    input  logic [TAG_W-1:0]   tag,
    input  logic               tag_en,
    input  logic               unmap,
    input  logic               half,
    output logic [31:0]        word
);
    import pte_pkg::*;

    logic [63:0] ent;

    always_comb begin
        ent                      = '0;
        ent[PHYS_W-1:0]          = phys;
        ent[POS_VALID]           = 1'b1;
        ent[POS_RDOK]            = ent[POS_RDOK] | ~wo;
        ent[POS_TGT +: 2]        = ent[POS_TGT +: 2] | tgt;
        ent[POS_SYS]             = ent[POS_SYS] | sys;
        ent[POS_LOG +: LOG_W]    = ent[POS_LOG +: LOG_W] | log_sz;
        ent[POS_MTYPE +: MTYPE_W] = ent[POS_MTYPE +: MTYPE_W] | mtype;
        if (tag_en) ent[POS_TAG +: TAG_W] = ent[POS_TAG +: TAG_W] | tag;
        if (unmap) ent = '0;
        word = half ? ent[63:32] : ent[31:0];
    end
endmodule

// File: rtl/pte_run_writer.sv
module pte_run_writer #(
    parameter int IDX_W   = 20,
    parameter int CNT_W   = 20,
    parameter int PHYS_W  = 40,
    parameter int MTYPE_W = 9,
    parameter int TAG_W   = 15,
    parameter int MAX_LOG = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PHYS_W-1:0]         stolen_base,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_unmap,
    input  logic [IDX_W-1:0]          req_index,
    input  logic [CNT_W-1:0]          req_count,
    input  logic [PHYS_W-1:0]         req_phys,
    input  logic [MTYPE_W-1:0]        req_mtype,
    input  logic [5:0]                req_pshift,
    input  logic [TAG_W-1:0]          req_tag_base,
    input  logic [PHYS_W-1:0]         req_delta,
    input  logic                      req_sys,
    input  logic                      req_wo,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [IDX_W+2:0]          wr_addr,
    output logic [31:0]               wr_data,
    output logic                      done
);
    import pte_pkg::*;

    localparam int LOG_W   = $clog2(MAX_LOG + 1);
    localparam int CHUNK_W = MAX_LOG + 1;

    typedef struct packed {
        wr_state_e          st;
        logic               half;
        logic               unmap;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   remain;
        logic [CHUNK_W-1:0] chunk_left;
        logic [LOG_W-1:0]   log_sz;
        logic [PHYS_W-1:0]  phys;
        logic [PHYS_W-1:0]  delta;
        logic [TAG_W-1:0]   tag;
        logic [TAG_W-1:0]   tag_base;
        logic [1:0]         tgt;
        logic               sys;
        logic               wo;
        logic [MTYPE_W-1:0] mtype;
        logic [5:0]         pshift;
        logic               done;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0]  sel_idx;
    logic [CNT_W-1:0]  sel_rem;
    logic [LOG_W-1:0]  sel_log;
    logic [PHYS_W-1:0] step_bytes;
    logic [PHYS_W-1:0] phys_adv;
    logic [PHYS_W-1:0] delta_adv;
    logic [PHYS_W-1:0] tc_delta;
    logic [TAG_W-1:0]  tc_base;
    logic [1:0]        tc_comp;
    logic [TAG_W-1:0]  tc_tag;
    logic              idle;
    logic              fire;

    assign idle = (q.st == ST_IDLE);
    assign fire = (q.st == ST_WRITE) && wr_ready;

    // Chunk selection looks at the request when idle, else at the next entry
    always_comb begin
        sel_idx    = idle ? req_index : q.idx + IDX_W'(1);
        sel_rem    = idle ? req_count : q.remain - CNT_W'(1);
        step_bytes = (PHYS_W'(1) << q.log_sz) << q.pshift;
        phys_adv   = q.phys + step_bytes;
        delta_adv  = q.delta + step_bytes;
        tc_delta   = idle ? req_delta : delta_adv;
        tc_base    = idle ? req_tag_base : q.tag_base;
        tc_comp    = idle ? req_mtype[COMP_LSB +: 2] : q.mtype[COMP_LSB +: 2];
    end

    pte_chunk_pick #(
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W),
        .MAX_LOG(MAX_LOG),
        .LOG_W  (LOG_W)
    ) u_pick (
        .idx   (sel_idx),
        .remain(sel_rem),
        .log_sz(sel_log)
    );

    pte_tag_calc #(
        .PHYS_W(PHYS_W),
        .TAG_W (TAG_W)
    ) u_tag (
        .tag_base(tc_base),
        .delta   (tc_delta),
        .comp    (tc_comp),
        .tag     (tc_tag)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (idle) begin
            if (req_valid) begin
                if (req_count == '0) begin
                    d.done = 1'b1;
                end else begin
                    d.st         = ST_WRITE;
                    d.half       = 1'b0;
                    d.unmap      = req_unmap;
                    d.idx        = req_index;
                    d.remain     = req_count;
                    d.log_sz     = sel_log;
                    d.chunk_left = CHUNK_W'(1) << sel_log;
                    d.phys       = req_phys + stolen_base;
                    d.tgt        = (stolen_base != '0) ? 2'd3 : 2'd0;
                    d.delta      = req_delta;
                    d.tag_base   = req_tag_base;
                    d.tag        = tc_tag;
                    d.sys        = req_sys;
                    d.wo         = req_wo;
                    d.mtype      = req_mtype;
                    d.pshift     = req_pshift;
                end
            end
        end else if (fire) begin
            if (!q.half) begin
                d.half = 1'b1;
            end else begin
                d.half   = 1'b0;
                d.idx    = q.idx + IDX_W'(1);
                d.remain = q.remain - CNT_W'(1);
                if (q.remain == CNT_W'(1)) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else if (q.chunk_left == CHUNK_W'(1)) begin
                    d.log_sz     = sel_log;
                    d.chunk_left = CHUNK_W'(1) << sel_log;
                    d.phys       = phys_adv;
                    d.delta      = delta_adv;
                    d.tag        = tc_tag;
                end else begin
                    d.chunk_left = q.chunk_left - CHUNK_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    pte_entry_enc #(
        .PHYS_W (PHYS_W),
        .MTYPE_W(MTYPE_W),
        .TAG_W  (TAG_W),
        .LOG_W  (LOG_W)
    ) u_enc (
        .phys  (q.phys),
        .tgt   (q.tgt),
        .sys   (q.sys),
        .wo    (q.wo),
        .log_sz(q.log_sz),
        .mtype (q.mtype),
        .tag   (q.tag),
        .tag_en(q.mtype[COMP_LSB +: 2] != 2'd0),
        .unmap (q.unmap),
        .half  (q.half),
        .word  (wr_data)
    );

    assign req_ready = idle;
    assign wr_valid  = (q.st == ST_WRITE);
    assign wr_addr   = {q.idx, q.half, 2'b00};
    assign done      = q.done;

    // R2: a stalled word holds address and data
    a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R2: accepted words advance the byte address by 4
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_valid || (wr_addr == $past(wr_addr) + (IDX_W+3)'(4)));

    // R6: a run starts aligned and fits in what remains
    a_r6_run_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !q.half && q.chunk_left == (CHUNK_W'(1) << q.log_sz)) |->
        (((q.idx & IDX_W'((CHUNK_W'(1) << q.log_sz) - CHUNK_W'(1))) == '0) &&
         (q.remain >= CNT_W'(q.chunk_left))));

    // R9: unmap writes only zero words
    a_r9_unmap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && q.unmap |-> wr_data == 32'd0);

    // R10: no word is offered while a request can be taken
    a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wr_valid);

    // R10 and R11: done follows a final word or a zero-count request
    a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ready) ||
                        $past(req_valid && req_ready && req_count == '0));
endmodule

// File: tb/pte_run_writer_bench.sv
module pte_run_writer_bench;
    localparam int IDX_W = 20;
    localparam int CNT_W = 20;
    localparam int PW    = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PW-1:0]   stolen_base = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_unmap = 1'b0;
    logic [IDX_W-1:0] req_index = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic [PW-1:0]   req_phys = '0;
    logic [8:0]      req_mtype = '0;
    logic [5:0]      req_pshift = '0;
    logic [14:0]     req_tag_base = '0;
    logic [PW-1:0]   req_delta = '0;
    logic            req_sys = 1'b0;
    logic            req_wo = 1'b0;
    logic            wr_valid;
    logic            wr_ready = 1'b0;
    logic [IDX_W+2:0] wr_addr;
    logic [31:0]     wr_data;
    logic            done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    pte_run_writer u_pte_run_writer (
        .clk(clk), .rst_n(rst_n), .stolen_base(stolen_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_unmap(req_unmap),
        .req_index(req_index), .req_count(req_count), .req_phys(req_phys),
        .req_mtype(req_mtype), .req_pshift(req_pshift), .req_tag_base(req_tag_base),
        .req_delta(req_delta), .req_sys(req_sys), .req_wo(req_wo),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Wait for one accepted word and compare it; stall_mode 1 drops ready on every third cycle
    task automatic expect_word(input int stall_mode, input logic [IDX_W+2:0] ea,
                               input logic [31:0] ed, input string req);
        forever begin
            @(negedge clk);
            cyc++;
            wr_ready = !(stall_mode == 1 && (cyc % 3) == 1);
            if (wr_valid && wr_ready) break;
        end
        check(wr_addr == ea, "R2 address", longint'(wr_addr), longint'(ea));
        check(wr_data == ed, req, longint'(wr_data), longint'(ed));
    endtask

    task automatic run_req(input bit unmap, input int idx, input int cnt,
                           input logic [PW-1:0] phys, input logic [8:0] mt,
                           input int psh, input logic [14:0] tbase,
                           input logic [PW-1:0] dl, input bit sys, input bit wo,
                           input int stall_mode, input bit inject, input string req);
        logic [PW-1:0] mp;
        logic [PW-1:0] md;
        logic [1:0]    tgt;
        logic [1:0]    comp;
        logic [14:0]   tg;
        logic [31:0]   lo;
        logic [31:0]   hi;
        int            e_idx;
        int            rem;
        int            lg;
        bit            first;
        @(negedge clk);
        req_valid = 1'b1; req_unmap = unmap; req_index = IDX_W'(idx);
        req_count = CNT_W'(cnt); req_phys = phys; req_mtype = mt;
        req_pshift = 6'(psh); req_tag_base = tbase; req_delta = dl;
        req_sys = sys; req_wo = wo;
        @(negedge clk);
        check(req_ready == 1'b0, "R10 busy", longint'(req_ready), 0);
        if (inject) begin
            // A different request while busy must be ignored
            req_index = IDX_W'(999); req_count = CNT_W'(3);
            req_phys = 40'hFF_FFFF_F000; req_mtype = 9'h1FF; req_unmap = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        mp    = phys + stolen_base;
        tgt   = (stolen_base != '0) ? 2'd3 : 2'd0;
        comp  = mt[8:7];
        md    = dl;
        e_idx = idx;
        rem   = cnt;
        first = 1'b1;
        while (rem > 0) begin
            lg = 0;
            for (int s = 0; s <= 7; s++)
                if (rem >= (1 << s) && (e_idx % (1 << s)) == 0) lg = s;
            tg = 15'(tbase + 15'(md >> 16) * 15'(comp));
            lo = mp[31:0] | 32'd1 | (32'(tgt) << 4) | (32'(sys) << 6)
                 | (32'(!wo) << 3) | (32'(lg) << 7);
            hi = 32'(mp[39:32]) | (32'(mt) << 8) | ((comp != 0) ? (32'(tg) << 17) : 32'd0);
            if (unmap) begin lo = '0; hi = '0; end
            for (int k = 0; k < (1 << lg); k++) begin
                expect_word(stall_mode, (IDX_W+3)'(e_idx) << 3, lo, req);
                if (first) begin
                    req_valid = 1'b0;
                    first = 1'b0;
                end
                expect_word(stall_mode, ((IDX_W+3)'(e_idx) << 3) + 4, hi, req);
                e_idx++;
                rem--;
            end
            mp = mp + ((PW'(1) << lg) << psh);
            md = md + ((PW'(1) << lg) << psh);
        end
        @(negedge clk);
        check(done == 1'b1, "R10 done pulse", longint'(done), 1);
        check(req_ready == 1'b1, "R10 idle again", longint'(req_ready), 1);
        @(negedge clk);
        check(done == 1'b0 && wr_valid == 1'b0, "R10 single pulse", longint'({done, wr_valid}), 0);
        wr_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", longint'(req_ready), 1);
        check(wr_valid == 1'b0, "R1 no write", longint'(wr_valid), 0);
        check(done == 1'b0, "R1 done low", longint'(done), 0);
    endtask

    task automatic t_zero_count();
        @(negedge clk);
        req_valid = 1'b1; req_count = '0; req_index = IDX_W'(17); req_unmap = 1'b0;
        wr_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b1, "R11 done", longint'(done), 1);
        check(wr_valid == 1'b0, "R11 no write", longint'(wr_valid), 0);
        @(negedge clk);
        check(done == 1'b0 && wr_valid == 1'b0, "R11 quiet", longint'({done, wr_valid}), 0);
        wr_ready = 1'b0;
    endtask

    task automatic t_aligned_long();
        // 128-entry run then a 2-entry run, address moves by 128 pages of 4 KiB
        run_req(1'b0, 0, 130, 40'h12_3400_0000, 9'h05A, 12, 15'h0, '0,
                1'b0, 1'b0, 0, 1'b0, "R3/R4/R6/R7 aligned");
    endtask

    task automatic t_misaligned_stall();
        run_req(1'b0, 5, 20, 40'h00_8000_0000, 9'h011, 16, 15'h0, '0,
                1'b1, 1'b1, 1, 1'b1, "R3/R6/R7 misaligned with stall");
    endtask

    task automatic t_compress();
        run_req(1'b0, 64, 72, 40'h03_0000_0000, 9'h1C3, 16, 15'h0100, 40'h0003_0000,
                1'b0, 1'b0, 1, 1'b0, "R8 factor 3");
        run_req(1'b0, 3, 2, 40'h00_0010_0000, 9'h080, 12, 15'h7FFE, 40'h0005_0000,
                1'b0, 1'b1, 0, 1'b0, "R8 factor 1 wrap");
    endtask

    task automatic t_stolen();
        stolen_base = 40'h10_0000_0000;
        run_req(1'b0, 8, 4, 40'h00_2000_0000, 9'h022, 12, 15'h0, '0,
                1'b1, 1'b0, 0, 1'b0, "R5 stolen");
        stolen_base = '0;
    endtask

    task automatic t_unmap();
        run_req(1'b1, 2, 5, 40'h05_5555_5000, 9'h1FF, 12, 15'h1234, 40'hFFFF_0000,
                1'b1, 1'b0, 1, 1'b0, "R9 unmap");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_count();
        t_aligned_long();
        t_misaligned_stall();
        t_compress();
        t_stolen();
        t_unmap();
        t_zero_count();
        finish_run();
    end
endmodule